// File: doc/BRIEF.md
# Two-Channel Compare Timer

This block holds two independent 32-bit up-counters, each paired with a compare value and a small control register. While a channel's count enable is set, its counter advances by one on every clock. When the counter equals the compare value, the block records a pending event for that channel in a shared status register. The counter then keeps running unless the channel's auto-stop bit is set. Each channel drives its own interrupt line, which is the pending bit qualified by that channel's interrupt enable.

Software reaches the block through a plain single-cycle port with a write strobe, a read strobe, a byte address and 32-bit data. Read data is registered and appears one cycle after the read strobe. To arm a one-shot event, software writes zero to the counter, writes the distance to the compare register, and then sets the enable bits. It acknowledges the event by writing a one to the channel's status bit.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset every control, compare, counter and status register reads zero, both interrupt lines are low and read data is zero.
- R2: Channel i control sits at byte offset 0x00+4i, compare at 0x18+4i, counter at 0x48+4i, and status at 0x60. A read returns the register on the read data one cycle after the read strobe. Control keeps bits [2:0] only: bit 0 is count enable, bit 1 is interrupt enable and bit 2 is auto-stop. Higher control bits read zero.
- R3: A counter increases by exactly one per clock while its count enable is set, and holds its value while the enable is clear.
- R4: A counter can be written at any time, and a write takes precedence over that cycle's increment.
- R5: When a channel's count enable is set and its counter equals its compare value, status bit i (bit index equal to channel number) is set on the next clock edge. With the counter at zero and the compare at M, the event is recorded on the (M+1)th edge after the control write.
- R6: Interrupt line i is high exactly when status bit i and interrupt enable bit 1 of channel i are both set.
- R7: Writing the status register clears each bit written as one and leaves bits written as zero. Writing 0xFFFF clears every pending bit.
- R8: If a compare event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: A counter wraps from 0xFFFFFFFF to zero. With auto-stop clear, it keeps counting after a compare event.
- R10: With auto-stop set, a compare event clears that channel's count enable on the same edge that sets its status bit. The counter then holds and the other control bits keep their values.
- R11: Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 2 | Per-channel interrupt lines |

## Verification
The bench builds the block with its defaults: two channels, 32-bit data and an 8-bit address. With these values both status bits can be set and cleared independently, and the byte offsets match the decode described above. Because the data width is 32, the wrap corner is reached by loading the counter close to 0xFFFFFFFF rather than by waiting for it to count there. Cycle-exact event timing is observed on the interrupt pins. The set-versus-clear collision is placed on the exact edge where the compare event is recorded.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  // control bits: [2] auto-stop, [1] interrupt enable, [0] count enable
  typedef struct packed {
    logic auto_stop;
    logic irq_en;
    logic cnt_en;
  } dmt_ctrl_t;

  localparam int unsigned CTRL_W     = $bits(dmt_ctrl_t);
  localparam int unsigned CTRL_BASE  = 'h00;
  localparam int unsigned MATCH_BASE = 'h18;
  localparam int unsigned COUNT_BASE = 'h48;
  localparam int unsigned STAT_ADDR  = 'h60;
  localparam int unsigned CH_STRIDE  = 4;
endpackage

// File: rtl/dmt_addr_decode.sv
module dmt_addr_decode #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] sel_ctrl,
  output logic [NUM_CH-1:0] sel_match,
  output logic [NUM_CH-1:0] sel_count,
  output logic              sel_stat,
  output logic              mapped
);
  import dmt_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel_ctrl[i]  = (addr == ADDR_W'(CTRL_BASE  + CH_STRIDE * i));
    assign sel_match[i] = (addr == ADDR_W'(MATCH_BASE + CH_STRIDE * i));
    assign sel_count[i] = (addr == ADDR_W'(COUNT_BASE + CH_STRIDE * i));
  end

  assign sel_stat = (addr == ADDR_W'(STAT_ADDR));
  assign mapped   = (|sel_ctrl) | (|sel_match) | (|sel_count) | sel_stat;
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_match,
  input  logic              wr_count,
  input  logic [DATA_W-1:0] wdata,
  output dmt_pkg::dmt_ctrl_t ctrl_o,
  output logic [DATA_W-1:0] match_o,
  output logic [DATA_W-1:0] count_o,
  output logic              hit_o
);
  import dmt_pkg::*;

  dmt_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] count_q;

  assign hit_o = ctrl_q.cnt_en && (count_q == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      match_q <= '0;
      count_q <= '0;
    end else begin
      if (wr_ctrl)
        ctrl_q <= dmt_ctrl_t'(wdata[CTRL_W-1:0]);
      else if (hit_o && ctrl_q.auto_stop)
        ctrl_q.cnt_en <= 1'b0;

      if (wr_match)
        match_q <= wdata;

      if (wr_count)
        count_q <= wdata;
      else if (ctrl_q.cnt_en)
        count_q <= count_q + 1'b1;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign match_o = match_q;
  assign count_o = count_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.cnt_en && !wr_count) |=> $stable(count_q)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.cnt_en && !wr_count) |=> (count_q == DATA_W'($past(count_q) + 1'b1))); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> (count_q == $past(wdata))); // R4
  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (rst)
    (hit_o && ctrl_q.auto_stop && !wr_ctrl) |=> !ctrl_q.cnt_en); // R10
endmodule

// File: rtl/dmt_status.sv
module dmt_status #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] status_o
);
  logic [NUM_CH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign status_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R7
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(clr_i)) == ($past(pend_q | set_i) & ~$past(clr_i)))); // R7
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq_o
);
  import dmt_pkg::*;

  logic [NUM_CH-1:0] sel_ctrl, sel_match, sel_count;
  logic              sel_stat, mapped;
  logic [NUM_CH-1:0] hit_w, status_w, clr_w;
  dmt_ctrl_t         ctrl_w  [NUM_CH];
  logic [DATA_W-1:0] match_w [NUM_CH];
  logic [DATA_W-1:0] count_w [NUM_CH];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  dmt_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .sel_ctrl(sel_ctrl), .sel_match(sel_match),
    .sel_count(sel_count), .sel_stat(sel_stat), .mapped(mapped)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dmt_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_ctrl(wr_en && sel_ctrl[i]),
      .wr_match(wr_en && sel_match[i]),
      .wr_count(wr_en && sel_count[i]),
      .wdata(wdata),
      .ctrl_o(ctrl_w[i]), .match_o(match_w[i]), .count_o(count_w[i]),
      .hit_o(hit_w[i])
    );
    assign irq_o[i] = status_w[i] & ctrl_w[i].irq_en;
  end

  assign clr_w = (wr_en && sel_stat) ? wdata[NUM_CH-1:0] : '0;

  dmt_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst(rst), .set_i(hit_w), .clr_i(clr_w), .status_o(status_w)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ctrl[i])  rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_w[i]};
      if (sel_match[i]) rd_mux = match_w[i];
      if (sel_count[i]) rd_mux = count_w[i];
    end
    if (sel_stat) rd_mux = {{(DATA_W-NUM_CH){1'b0}}, status_w};
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata == '0)); // R11
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o[0]) |-> status_w[0]); // R6
endmodule

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_o;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  dual_cmp_timer uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  always #4 clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [1:0] e, input string t);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: hung=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk_irq(2'b00, "R1 irq after reset");
    rd(8'h00, 0, "R1 ctrl0"); rd(8'h04, 0, "R1 ctrl1");
    rd(8'h18, 0, "R1 match0"); rd(8'h1C, 0, "R1 match1");
    rd(8'h48, 0, "R1 count0"); rd(8'h4C, 0, "R1 count1");
    rd(8'h60, 0, "R1 status");
    // R2 map and readback
    wr(8'h18, 32'h1234_5678); rd(8'h18, 32'h1234_5678, "R2 match0");
    wr(8'h1C, 32'hCAFE_0001); rd(8'h1C, 32'hCAFE_0001, "R2 match1");
    wr(8'h04, 32'hFFFF_FFF8); rd(8'h04, 0, "R2 ctrl1 upper bits");
    wr(8'h4C, 32'd5); idle(10); rd(8'h4C, 32'd5, "R3 count1 holds");
    // R3 counting
    wr(8'h48, 0); wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 1); idle(9); wr(8'h00, 0);
    rd(8'h48, 32'd10, "R3 count0 steps");
    // R4 write beats increment
    wr(8'h00, 1); idle(3); wr(8'h48, 32'h100); wr(8'h00, 0);
    rd(8'h48, 32'h101, "R4 count load while running");
    // R5 / R6 event timing
    wr(8'h48, 0); wr(8'h18, 32'd5); wr(8'h00, 3);
    idle(5); chk_irq(2'b00, "R5 before event");
    idle(1); chk_irq(2'b01, "R5 event on M+1 edge");
    wr(8'h00, 1); chk_irq(2'b00, "R6 irq masked");
    rd(8'h60, 32'd1, "R6 status stays pending");
    wr(8'h00, 0);
    // R7 write-one-to-clear
    wr(8'h60, 32'h2); rd(8'h60, 32'd1, "R7 zero leaves bit");
    wr(8'h60, 32'h1); rd(8'h60, 32'd0, "R7 one clears bit");
    wr(8'h4C, 0); wr(8'h1C, 32'd2); wr(8'h04, 1); idle(5); wr(8'h04, 0);
    wr(8'h48, 0); wr(8'h18, 32'd1); wr(8'h00, 1); idle(5); wr(8'h00, 0);
    rd(8'h60, 32'd3, "R7 both pending");
    wr(8'h60, 32'hFFFF); rd(8'h60, 32'd0, "R7 clear all");
    // R8 set wins
    wr(8'h48, 0); wr(8'h18, 32'd3); wr(8'h00, 1);
    idle(3); wr(8'h60, 32'h1); wr(8'h00, 0);
    rd(8'h60, 32'd1, "R8 set beats clear");
    wr(8'h60, 32'hFFFF);
    // R9 wrap and keep counting
    wr(8'h48, 32'hFFFF_FFFE); wr(8'h18, 32'd1); wr(8'h00, 1);
    idle(6); wr(8'h00, 0);
    rd(8'h48, 32'd5, "R9 wrapped count");
    rd(8'h60, 32'd1, "R9 event after wrap");
    wr(8'h60, 32'hFFFF);
    // R10 auto-stop
    wr(8'h48, 0); wr(8'h18, 32'd4); wr(8'h00, 32'h5); idle(10);
    rd(8'h48, 32'd5, "R10 counter halted");
    rd(8'h00, 32'd4, "R10 enable dropped");
    rd(8'h60, 32'd1, "R10 event recorded");
    // R11 unmapped
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h61, 32'hFFFF_FFFF);
    rd(8'h08, 0, "R11 unmapped read");
    rd(8'h50, 0, "R11 unmapped read 2");
    rd(8'h1C, 32'd2, "R11 match1 untouched");
    rd(8'h60, 32'd1, "R11 status untouched");
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule